// File: doc/BRIEF.md
# Oscillator Clock Control with Halt and Wake-Up

This block turns a free-running reference clock into the clocking strobes of a small 4-bit controller. It emits a system-clock tick, which either fires on every reference cycle or on every second one, and an instruction-clock tick that fires on every third system tick. A 4-bit mode register chooses the rate. Bit 3 of that register is the speed select, and the lower three bits are plain storage.

A power-off strobe from the core puts the block into a halt state. While halted, all ticks stop and the mode register is held at its reset value. The block leaves the halt state on either of two events:
- a falling edge on a key-input pin whose group is enabled;
- an external wake pin reaching its selected level.

Leaving halt starts a stabilization wait of a fixed number of reference cycles. Ticks resume only when that wait has ended. Outside this block the reference clock stands for the oscillator, so stopping the oscillation is shown as the ticks being suppressed.

Top module: `osc_clock_ctrl`

## Requirements
- R1: After reset, the register reads 4'b1000 and `clk_ready_o` stays low for WAIT_CYC cycles. It then rises, and the block runs in the halved-rate mode.
- R2: When register bit 3 is 0, `sys_tick_o` is high on every cycle. When bit 3 is 1, `sys_tick_o` is high on every second cycle.
- R3: All 16 register values read back exactly as written. Bits 2..0 do not change the tick rate.
- R4: A change of bit 3 only takes effect at the end of a two-cycle period. In halved mode, two ticks are never adjacent: within two cycles of a switch to halved rate, the ticks strictly alternate.
- R5: `instr_tick_o` is high only together with `sys_tick_o`, and it marks every third system tick.
- R6: While running, a `pof_i` pulse halts the block on the next edge. While halted, `clk_ready_o` is low, no ticks are issued, the register reads 4'b1000, and writes have no effect.
- R7: While halted, a 1-to-0 transition on key pin i wakes the block when `key_en_i[i / GRP_W]` is 1. A key edge in a disabled group does not wake it.
- R8: While halted, wake pin j wakes the block when `wk_pin_i[j]` equals `wk_lvl_i[j]`. The opposite level does not wake it.
- R9: A wake event leaves halt on the next edge. The block then spends WAIT_CYC cycles with `clk_ready_o` low and no ticks before `clk_ready_o` rises.
- R10: After a wake, the divide-by-3 count starts from zero. The first instruction tick is the third system tick, which falls on the sixth ready cycle in halved mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Mode register write strobe |
| reg_wdata_i | input | 4 | Mode register write data |
| reg_rdata_o | output | 4 | Mode register read data |
| pof_i | input | 1 | Power-off strobe |
| key_i | input | N_GRP*GRP_W | Key input pins, falling-edge wake |
| key_en_i | input | N_GRP | Per-group key wake enable |
| wk_pin_i | input | N_WPIN | Level wake pins |
| wk_lvl_i | input | N_WPIN | Wake level per pin (0 low, 1 high) |
| sys_tick_o | output | 1 | System clock enable tick |
| instr_tick_o | output | 1 | Instruction clock enable tick |
| clk_ready_o | output | 1 | Clocks running after stabilization |
| halted_o | output | 1 | In halt state |

## Verification
Each result has a fixed latency from its stimulus:
- A register write shows on the read port one edge after the write.
- `halted_o` follows a power-off strobe or a wake event one edge later.
- `clk_ready_o` rises WAIT_CYC edges after halt is left.
- The first instruction tick comes on the sixth ready cycle.

The bench drives its inputs and samples the outputs 1 ns after a rising edge. It then advances by exact edge counts to these slots, so every check lands on the cycle where the value is due. Rate checks wait four cycles after a write before counting ticks in fixed windows, which keeps the boundary delay of R4 out of the count.

// File: rtl/ckc_pkg.sv
`timescale 1ns/1ps
package ckc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_WAIT = 2'd2
  } ckc_state_e;

  localparam logic [3:0] MR_INIT = 4'b1000;
  localparam int         SEL_BIT = 3;
endpackage

// File: rtl/ckc_wake.sv
`timescale 1ns/1ps
module ckc_wake #(
  parameter int N_GRP  = 4,
  parameter int GRP_W  = 2,
  parameter int N_WPIN = 2,
  localparam int N_KEY = N_GRP * GRP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_KEY-1:0]  key_i,
  input  logic [N_GRP-1:0]  key_en_i,
  input  logic [N_WPIN-1:0] wk_pin_i,
  input  logic [N_WPIN-1:0] wk_lvl_i,
  output logic              wake_o
);
  logic [N_KEY-1:0]  key_q;
  logic [N_GRP-1:0]  grp_fall;
  logic [N_WPIN-1:0] lvl_hit;

  // pull-up idle level: reset to all ones so release cannot look like an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) key_q <= '1;
    else         key_q <= key_i;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_fall[g] = |(key_q[g*GRP_W +: GRP_W] & ~key_i[g*GRP_W +: GRP_W]);
  end

  assign lvl_hit = ~(wk_pin_i ^ wk_lvl_i);
  assign wake_o  = (|(grp_fall & key_en_i)) | (|lvl_hit);
endmodule

// File: rtl/ckc_seq.sv
`timescale 1ns/1ps
module ckc_seq
  import ckc_pkg::*;
#(
  parameter int WAIT_CYC = 256,
  localparam int CW = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pof_i,
  input  logic       wake_i,
  output ckc_state_e state_o
);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

  ckc_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RUN:  if (pof_i) state_q <= ST_HALT;
        ST_HALT: if (wake_i) begin
          state_q <= ST_WAIT;
          cnt_q   <= '0;
        end
        ST_WAIT: begin
          if (cnt_q == LAST) state_q <= ST_RUN;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign state_o = state_q;

  AST_POF_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && pof_i) |=> (state_q == ST_HALT)); // R6
  AST_WAKE_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT && wake_i) |=> (state_q == ST_WAIT && cnt_q == '0)); // R9
  AST_RUN_AFTER_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) != ST_RUN)
      |-> ($past(state_q) == ST_WAIT && $past(cnt_q) == LAST)); // R9
endmodule

// File: rtl/ckc_div.sv
`timescale 1ns/1ps
module ckc_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic sel_i,
  output logic sys_tick_o,
  output logic instr_tick_o
);
  logic       ph_q;
  logic       act_sel_q;
  logic [1:0] cnt3_q;
  logic       sys_tick;

  assign sys_tick     = run_i & (~act_sel_q | ph_q);
  assign sys_tick_o   = sys_tick;
  assign instr_tick_o = sys_tick & (cnt3_q == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= 1'b0;
      act_sel_q <= 1'b1;
      cnt3_q    <= '0;
    end else if (!run_i) begin
      ph_q      <= 1'b0;
      act_sel_q <= sel_i;
      cnt3_q    <= '0;
    end else begin
      ph_q <= ~ph_q;
      // speed select follows only at the close of a /2 period
      if (ph_q) act_sel_q <= sel_i;
      if (sys_tick) cnt3_q <= (cnt3_q == 2'd2) ? 2'd0 : cnt3_q + 2'd1;
    end
  end

  AST_SEL_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && act_sel_q != $past(act_sel_q)) |-> $past(ph_q)); // R4
  AST_SLOW_NO_ADJACENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && act_sel_q && $past(act_sel_q) && sys_tick)
      |-> !$past(sys_tick)); // R4
  AST_INSTR_IN_SYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_tick_o |-> sys_tick); // R5
  AST_CNT3_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt3_q != 2'd3); // R5
endmodule

// File: rtl/osc_clock_ctrl.sv
`timescale 1ns/1ps
module osc_clock_ctrl
  import ckc_pkg::*;
#(
  parameter int WAIT_CYC = 256,
  parameter int N_GRP    = 4,
  parameter int GRP_W    = 2,
  parameter int N_WPIN   = 2,
  localparam int N_KEY   = N_GRP * GRP_W
) (
  input  logic              osc_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_wdata_i,
  output logic [3:0]        reg_rdata_o,
  input  logic              pof_i,
  input  logic [N_KEY-1:0]  key_i,
  input  logic [N_GRP-1:0]  key_en_i,
  input  logic [N_WPIN-1:0] wk_pin_i,
  input  logic [N_WPIN-1:0] wk_lvl_i,
  output logic              sys_tick_o,
  output logic              instr_tick_o,
  output logic              clk_ready_o,
  output logic              halted_o
);
  ckc_state_e state;
  logic       wake;
  logic [3:0] mr_q;
  logic       run;

  assign run         = (state == ST_RUN);
  assign clk_ready_o = run;
  assign halted_o    = (state == ST_HALT);
  assign reg_rdata_o = mr_q;

  always_ff @(posedge osc_i or negedge rst_ni) begin
    if (!rst_ni)                mr_q <= MR_INIT;
    else if (state == ST_HALT)  mr_q <= MR_INIT;
    else if (reg_we_i)          mr_q <= reg_wdata_i;
  end

  ckc_wake #(.N_GRP(N_GRP), .GRP_W(GRP_W), .N_WPIN(N_WPIN)) u_wake (
    .clk_i    (osc_i),
    .rst_ni   (rst_ni),
    .key_i    (key_i),
    .key_en_i (key_en_i),
    .wk_pin_i (wk_pin_i),
    .wk_lvl_i (wk_lvl_i),
    .wake_o   (wake)
  );

  ckc_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
    .clk_i   (osc_i),
    .rst_ni  (rst_ni),
    .pof_i   (pof_i),
    .wake_i  (wake),
    .state_o (state)
  );

  ckc_div u_div (
    .clk_i        (osc_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .sel_i        (mr_q[SEL_BIT]),
    .sys_tick_o   (sys_tick_o),
    .instr_tick_o (instr_tick_o)
  );

  AST_HALT_MR_HELD: assert property (@(posedge osc_i) disable iff (!rst_ni)
    (halted_o && $past(halted_o)) |-> (mr_q == MR_INIT)); // R6
  AST_HALT_QUIET: assert property (@(posedge osc_i) disable iff (!rst_ni)
    !run |-> (!sys_tick_o && !instr_tick_o)); // R9
endmodule

// File: tb/tb_osc_clock_ctrl.sv
`timescale 1ns/1ps
module tb_osc_clock_ctrl;
  localparam int W     = 16;
  localparam int NG    = 4;
  localparam int GW    = 2;
  localparam int NW    = 2;
  localparam int NK    = NG * GW;

  logic          osc = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [3:0]    wdata = '0;
  logic [3:0]    rdata;
  logic          pof = 1'b0;
  logic [NK-1:0] key = '1;
  logic [NG-1:0] key_en = '0;
  logic [NW-1:0] wpin = '0;
  logic [NW-1:0] wlvl = '1;
  logic          sys_tick, instr_tick, ready, halted;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 osc = ~osc;

  osc_clock_ctrl #(.WAIT_CYC(W), .N_GRP(NG), .GRP_W(GW), .N_WPIN(NW)) dut (
    .osc_i(osc), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .pof_i(pof), .key_i(key), .key_en_i(key_en),
    .wk_pin_i(wpin), .wk_lvl_i(wlvl), .sys_tick_o(sys_tick),
    .instr_tick_o(instr_tick), .clk_ready_o(ready), .halted_o(halted)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge osc);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_mr(input logic [3:0] v);
    we = 1'b1; wdata = v;
    tick(1);
    we = 1'b0;
  endtask

  task automatic enter_halt(input string req);
    pof = 1'b1;
    tick(1);
    pof = 1'b0;
    check(halted == 1'b1 && ready == 1'b0, req, {30'd0, halted, ready}, 2);
  endtask

  // wake stimulus already applied; covers R9 and R10
  task automatic finish_wake(input string req);
    int nt;
    int first;
    tick(1);
    check(halted == 1'b0, req, halted, 0);
    nt = 0;
    for (int i = 0; i < W - 1; i++) begin
      if (sys_tick || ready) nt++;
      tick(1);
    end
    check(nt == 0 && ready == 1'b0, "R9 quiet wait", nt + ready, 0);
    tick(1);
    check(ready == 1'b1, "R9 ready after wait", ready, 1);
    // R10: first instruction tick on the sixth ready cycle
    first = 0;
    nt = 0;
    for (int c = 1; c <= 8 && first == 0; c++) begin
      if (sys_tick) nt++;
      if (instr_tick) first = c;
      else tick(1);
    end
    check(first == 6 && nt == 3, "R10 div3 restart", first * 10 + nt, 63);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    int gap;
    int seen;
    bit prev;
    bit ok;
    bit zero_seen;
    int first_zero;

    tick(3);
    rst_n = 1'b1;
    // R1 reset state
    check(rdata == 4'b1000, "R1 reset value", rdata, 8);
    tick(W - 1);
    check(ready == 1'b0, "R1 ready low during wait", ready, 0);
    tick(1);
    check(ready == 1'b1, "R1 ready after wait", ready, 1);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin cnt += sys_tick; tick(1); end
    check(cnt == 6, "R1 halved rate after reset", cnt, 6);

    // R2 R3 R5 sweep over all register values
    for (int v = 0; v < 16; v++) begin
      write_mr(4'(v));
      check(rdata == 4'(v), "R3 readback", rdata, v);
      tick(4);
      cnt = 0; gap = 0; seen = 0; ok = 1;
      for (int i = 0; i < 24; i++) begin
        if (instr_tick && !sys_tick) ok = 0;
        if (sys_tick) begin
          cnt++;
          gap++;
          if (instr_tick) begin
            if (seen > 0 && gap != 3) ok = 0;
            seen++;
            gap = 0;
          end
        end
        tick(1);
      end
      check(cnt == (v[3] ? 12 : 24), "R2 R3 tick rate", cnt, v[3] ? 12 : 24);
      check(ok && seen >= 2, "R5 instr every third", {31'd0, ok}, 1);
    end

    // R4 fast to slow switch at both phases
    for (int off = 0; off < 2; off++) begin
      write_mr(4'b0000);
      tick(4 + off);
      write_mr(4'b1000);
      zero_seen = 0; first_zero = -1; ok = 1; prev = 0;
      for (int i = 0; i < 12; i++) begin
        if (zero_seen && sys_tick == prev) ok = 0;
        if (!sys_tick && !zero_seen) begin zero_seen = 1; first_zero = i; end
        prev = sys_tick;
        tick(1);
      end
      check(ok && first_zero >= 0 && first_zero <= 2, "R4 no runt on switch", first_zero, 2);
    end

    // R6 halt
    write_mr(4'b0101);
    enter_halt("R6 halt entry");
    check(sys_tick == 1'b0, "R6 no ticks", sys_tick, 0);
    tick(1);
    check(rdata == 4'b1000, "R6 register forced", rdata, 8);
    write_mr(4'b0011);
    cnt = 0;
    for (int i = 0; i < 5; i++) begin cnt += sys_tick + instr_tick; tick(1); end
    check(rdata == 4'b1000 && cnt == 0, "R6 write ignored", rdata, 8);
    wpin[0] = 1'b1;
    finish_wake("R8 wake pin 0 high");
    wpin[0] = 1'b0;
    tick(1);

    // R7 key sweep: bit i belongs to group i/GW
    for (int p = 0; p < NK; p++) begin
      for (int mode = 0; mode < 2; mode++) begin
        enter_halt("R7 halt");
        key_en = (mode == 0) ? NG'(1 << (p / GW)) : ~NG'(1 << (p / GW));
        key[p] = 1'b0;
        if (mode == 0) begin
          finish_wake("R7 enabled key wake");
        end else begin
          tick(3);
          check(halted == 1'b1, "R7 disabled key no wake", halted, 1);
          key[p] = 1'b1;
          tick(1);
          check(halted == 1'b1, "R7 rising edge no wake", halted, 1);
          wlvl[1] = 1'b0;
          finish_wake("R8 wake pin 1 low");
          wlvl[1] = 1'b1;
        end
        key[p] = 1'b1; key_en = '0;
        tick(1);
      end
    end

    // R8 level pins
    for (int q = 0; q < NW; q++) begin
      for (int l = 0; l < 2; l++) begin
        wlvl[q] = l[0];
        wpin[q] = ~l[0];
        tick(1);
        enter_halt("R8 halt");
        tick(3);
        check(halted == 1'b1, "R8 opposite level no wake", halted, 1);
        wpin[q] = l[0];
        finish_wake("R8 matching level wake");
        wlvl[q] = 1'b1; wpin[q] = 1'b0;
        tick(1);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule